// File: doc/BRIEF.md
# Test-Pattern Sequence Monitor with Zero Tolerance

This block watches received converter samples and checks that they follow a known test pattern. The pattern is either a pseudo-random sequence from a linear feedback shift register or a simple incrementing ramp. The monitor does not run its own generator. It predicts each expected word from the last word it accepted, so it locks onto the incoming stream wherever that stream happens to start.

A word equal to zero is a legal sample, which lets ramps pass through zero. While the monitor is locked, a stray zero that does not fit the pattern causes no error. It only adds to the run of bad words that leads to a loss of lock.

The monitor has three outputs. A lock flag goes high when the stream is out of step. A one-cycle error pulse marks each bad word. A saturating counter tallies those error pulses.

Top module: `pn_seq_monitor`

## Requirements
- R1: After synchronous reset, pn_oos is 1, pn_err is 0 and err_count is 0.
- R2: With mode_ramp = 0, the expected word is the last accepted word shifted left by one bit. Its new bit 0 is the XOR of the last word's bits selected by the POLY_MASK parameter (bit i of the mask selects bit i). A word matches when it equals the expected word.
- R3: With mode_ramp = 1, the expected word is the last accepted word plus one, modulo 2^DATA_W. A word that wraps to zero matches and raises no error.
- R4: While pn_oos is 1, OOS_THRESHOLD consecutive valid words that match and are nonzero clear pn_oos in the cycle after the last of them. A zero or mismatching word restarts that run.
- R5: While pn_oos is 0, a valid word that is nonzero and mismatching raises pn_err for exactly one cycle, in the cycle after the word. pn_err is never raised for a word taken while pn_oos is 1.
- R6: While pn_oos is 0, a zero word that does not match raises no pn_err and does not change err_count. The monitor replaces it with the expected word, so the next word in the true sequence still matches.
- R7: While pn_oos is 0, OOS_THRESHOLD consecutive valid words that are zero or mismatching set pn_oos in the cycle after the last of them. A matching word restarts that run.
- R8: err_count increments by one with each pn_err pulse and holds at its all-ones value (2^ERR_CNT_W - 1) once reached.
- R9: Cycles with in_valid = 0 change no state, whatever the value of in_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks in_data as a sample to check |
| in_data | input | DATA_W | Received sample |
| mode_ramp | input | 1 | 0 selects the shift-register pattern, 1 selects the incrementing ramp |
| pn_oos | output | 1 | High while the stream is out of step with the pattern |
| pn_err | output | 1 | One-cycle pulse for each nonzero mismatch while locked |
| err_count | output | ERR_CNT_W | Saturating count of error pulses |

## Verification
Some properties are checked by assertions on every cycle:
- the lock flag holds through idle cycles;
- error pulses follow only valid words taken while locked;
- the run counter stays below its threshold;
- the error counter moves only on a pulse and sticks once saturated.

Other behaviour can only be shown by the bench's scenarios, which compare against a reference shift register and ramp held in the bench. These cover:
- the exact cycle at which lock is gained or lost after the threshold count;
- a dropped word replaced by zero passing silently;
- the double error that follows a single corrupted word;
- a ramp wrapping through zero.

// File: rtl/pn_mon_pkg.sv
package pn_mon_pkg;
  typedef enum logic {
    PAT_SHIFT = 1'b0,
    PAT_RAMP  = 1'b1
  } pat_mode_e;
endpackage

// File: rtl/pn_predict.sv
module pn_predict #(
  parameter int          DATA_W    = 16,
  parameter logic [DATA_W-1:0] POLY_MASK = 16'hD008
) (
  input  logic [DATA_W-1:0] basis,
  input  logic              mode_ramp,
  output logic [DATA_W-1:0] expected
);
  import pn_mon_pkg::*;

  logic feedback;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] ramped;

  always_comb begin
    feedback = ^(basis & POLY_MASK);
    shifted  = {basis[DATA_W-2:0], feedback};
    ramped   = basis + DATA_W'(1);
    if (pat_mode_e'(mode_ramp) == PAT_RAMP) expected = ramped;
    else                                    expected = shifted;
  end
endmodule

// File: rtl/pn_sync_track.sv
module pn_sync_track #(
  parameter int OOS_THRESHOLD = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic valid,
  input  logic hit,
  input  logic nonzero,
  output logic oos
);
  localparam int RUN_W = $clog2(OOS_THRESHOLD + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(OOS_THRESHOLD - 1);

  logic [RUN_W-1:0] run_q;
  logic             oos_q;
  logic             advance;

  // out of step: count clean matches; locked: count bad words
  assign advance = oos_q ? (hit & nonzero) : !hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      oos_q <= 1'b1;
      run_q <= '0;
    end else if (valid) begin
      if (advance) begin
        if (run_q == RUN_LAST) begin
          oos_q <= !oos_q;
          run_q <= '0;
        end else begin
          run_q <= run_q + RUN_W'(1);
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assign oos = oos_q;

  // R9
  oos_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(oos_q));

  // R7
  run_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run_q <= RUN_LAST);

  // R4
  relock_needs_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (oos_q && !(valid && hit && nonzero)) |=> oos_q);
endmodule

// File: rtl/pn_err_tally.sv
module pn_err_tally #(
  parameter int ERR_CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flag,
  output logic                 err,
  output logic [ERR_CNT_W-1:0] count
);
  logic                 err_q;
  logic [ERR_CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      err_q <= flag;
      if (flag && cnt_q != '1) cnt_q <= cnt_q + ERR_CNT_W'(1);
    end
  end

  assign err   = err_q;
  assign count = cnt_q;

  // R8
  cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !flag |=> $stable(cnt_q));

  // R8
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '1) |=> (cnt_q == '1));
endmodule

// File: rtl/pn_seq_monitor.sv
module pn_seq_monitor #(
  parameter int          DATA_W        = 16,
  parameter logic [DATA_W-1:0] POLY_MASK = 16'hD008,
  parameter int          OOS_THRESHOLD = 16,
  parameter int          ERR_CNT_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [DATA_W-1:0]    in_data,
  input  logic                 mode_ramp,
  output logic                 pn_oos,
  output logic                 pn_err,
  output logic [ERR_CNT_W-1:0] err_count
);
  logic [DATA_W-1:0] basis_q;
  logic [DATA_W-1:0] expected;
  logic              hit;
  logic              nonzero;
  logic              oos;
  logic              err_flag;
  logic              drop_zero;

  pn_predict #(.DATA_W(DATA_W), .POLY_MASK(POLY_MASK)) u_predict (
    .basis    (basis_q),
    .mode_ramp(mode_ramp),
    .expected (expected)
  );

  assign hit       = (in_data == expected);
  assign nonzero   = |in_data;
  assign drop_zero = !oos && !hit && !nonzero;
  assign err_flag  = in_valid && !oos && !hit && nonzero;

  // a stray zero while locked stands in for the word it replaced
  always_ff @(posedge clk) begin
    if (rst)           basis_q <= '0;
    else if (in_valid) basis_q <= drop_zero ? expected : in_data;
  end

  pn_sync_track #(.OOS_THRESHOLD(OOS_THRESHOLD)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .valid  (in_valid),
    .hit    (hit),
    .nonzero(nonzero),
    .oos    (oos)
  );

  pn_err_tally #(.ERR_CNT_W(ERR_CNT_W)) u_tally (
    .clk  (clk),
    .rst  (rst),
    .flag (err_flag),
    .err  (pn_err),
    .count(err_count)
  );

  assign pn_oos = oos;

  // R5
  err_only_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid || pn_oos) |=> !pn_err);

  // R9
  basis_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(basis_q));
endmodule

// File: tb/pn_seq_monitor_tb.sv
module pn_seq_monitor_tb;
  localparam int          CLK_PERIOD = 10;
  localparam int          W    = 16;
  localparam logic [W-1:0] MASK = 16'hD008;
  localparam int          THR  = 8;
  localparam int          CW   = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_data = '0;
  logic          mode_ramp = 1'b0;
  logic          pn_oos, pn_err;
  logic [CW-1:0] err_count;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] cur;

  always #(CLK_PERIOD/2) clk = ~clk;

  pn_seq_monitor #(.DATA_W(W), .POLY_MASK(MASK), .OOS_THRESHOLD(THR), .ERR_CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .mode_ramp(mode_ramp), .pn_oos(pn_oos), .pn_err(pn_err), .err_count(err_count)
  );

  function automatic logic [W-1:0] ref_next(input logic [W-1:0] x);
    return {x[W-2:0], ^(x & MASK)};
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [W-1:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    chk(pn_oos == 1'b1, "R1 oos", pn_oos, 1);
    chk(pn_err == 1'b0, "R1 err", pn_err, 0);
    chk(err_count == 0, "R1 count", err_count, 0);
  endtask

  task automatic t_pn_lock;
    cur = 16'h1234;
    send(cur);
    for (int i = 1; i < THR; i++) begin
      cur = ref_next(cur);
      send(cur);
    end
    chk(pn_oos == 1'b1, "R4 still out before threshold", pn_oos, 1);
    cur = ref_next(cur);
    send(cur);
    chk(pn_oos == 1'b0, "R2 R4 locked after threshold", pn_oos, 0);
    chk(err_count == 0, "R5 no errors while out of step", err_count, 0);
  endtask

  task automatic t_zero_skip;
    logic [W-1:0] skipped;
    skipped = ref_next(cur);
    send('0);
    chk(pn_err == 1'b0, "R6 zero no pulse", pn_err, 0);
    chk(pn_oos == 1'b0, "R6 zero keeps lock", pn_oos, 0);
    cur = ref_next(skipped);
    send(cur);
    chk(pn_err == 1'b0, "R6 word after zero matches", pn_err, 0);
    chk(err_count == 0, "R6 count unchanged", err_count, 0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 16'hBEEF;
    repeat (5) @(posedge clk);
    #1;
    chk(pn_oos == 1'b0 && pn_err == 1'b0, "R9 idle no change", {pn_oos, pn_err}, 0);
    cur = ref_next(cur);
    send(cur);
    chk(pn_err == 1'b0, "R9 basis untouched by idle data", pn_err, 0);
  endtask

  task automatic t_mismatch;
    cur = ref_next(cur);
    send(cur ^ 16'h0001);
    chk(pn_err == 1'b1, "R5 pulse on mismatch", pn_err, 1);
    chk(err_count == 1, "R8 count one", err_count, 1);
    cur = ref_next(cur);
    send(cur);
    chk(pn_err == 1'b1, "R2 prediction from corrupted word", pn_err, 1);
    chk(err_count == 2, "R8 count two", err_count, 2);
    cur = ref_next(cur);
    send(cur);
    chk(pn_err == 1'b0, "R5 pulse one cycle", pn_err, 0);
    chk(pn_oos == 1'b0, "R7 short run keeps lock", pn_oos, 0);
  endtask

  task automatic t_loss;
    for (int i = 0; i < THR - 1; i++) send('0);
    chk(pn_oos == 1'b0, "R7 lock held below threshold", pn_oos, 0);
    send('0);
    chk(pn_oos == 1'b1, "R7 lock lost at threshold", pn_oos, 1);
    chk(err_count == 2, "R6 zeros not counted", err_count, 2);
  endtask

  task automatic t_ramp;
    logic [W-1:0] r;
    mode_ramp = 1'b1;
    r = 16'hFFE0;
    send(r);
    for (int i = 0; i < 3; i++) begin r = r + 1'b1; send(r); end
    r = 16'hFFF0;
    send(r);
    for (int i = 1; i < THR; i++) begin r = r + 1'b1; send(r); end
    chk(pn_oos == 1'b1, "R4 run restarted by jump", pn_oos, 1);
    r = r + 1'b1;
    send(r);
    chk(pn_oos == 1'b0, "R3 R4 ramp lock", pn_oos, 0);
    for (int i = 0; i < 10; i++) begin
      r = r + 1'b1;
      send(r);
      chk(pn_err == 1'b0, "R3 ramp wrap through zero", pn_err, 0);
    end
    chk(r == 16'h0002 && pn_oos == 1'b0, "R3 ramp wrapped locked", r, 2);
    cur = r;
  endtask

  task automatic t_saturate;
    for (int g = 0; g < 10; g++) begin
      cur = cur + 1'b1;
      send(cur ^ 16'h8000);
      if (g == 0) chk(pn_err == 1'b1, "R5 ramp mismatch pulse", pn_err, 1);
      cur = cur + 1'b1;
      send(cur);
      cur = cur + 1'b1;
      send(cur);
    end
    chk(err_count == 4'hF, "R8 saturated", err_count, 15);
    chk(pn_oos == 1'b0, "R7 isolated errors keep lock", pn_oos, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_pn_lock();
    t_zero_skip();
    t_idle();
    t_mismatch();
    t_loss();
    t_ramp();
    t_saturate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule